// File: doc/BRIEF.md
# Serial Configuration Bitstream Memory

This block models a one-bit-wide read-only memory that holds an FPGA configuration bitstream and hands it out one bit per rising edge of a configuration clock. The clock comes from the receiving device. There is no address bus. An internal counter walks through the stored bits and stops at the last one. After the last stored bit has been delivered, the output reads a constant 1.

A single control pin acts as both reset and output enable. A parameter sets whether that pin is active-high or active-low. A separate standby input freezes the counter and the output register, and it releases the output.

The tri-state data pin is modelled as two signals: a data bit and a drive-enable flag. A write port loads the contents in simulation. It takes effect only while the shared reset is active.

Top module: `cfgrom_stream`

## Requirements
- R1: Parameter `RST_ACTIVE_HIGH` selects the active level of `rst_oe`. A value of 1 makes a high level active; a value of 0 makes a low level active.
- R2: When `rst_oe` is at its active level, `data_oe` is 0 whatever the level of `standby`. Each clock edge in this state returns the read position to bit 0 and sets `data_bit` to 1.
- R3: With reset inactive and `standby` low, `data_oe` is 1. The first edge after reset release places stored bit 0 on `data_bit`, and each further edge places the next bit.
- R4: With reset inactive and `standby` high, `data_oe` is 0, and clock edges change neither the read position nor `data_bit`. When `standby` returns low, delivery resumes with the next undelivered bit.
- R5: The read position saturates at bit `DEPTH-1`. On every running edge after that bit has been delivered, `data_bit` is 1.
- R6: Asserting reset in the middle of a stream, then releasing it, restarts delivery at bit 0.
- R7: A write (`wr_en`=1) stores `wr_bit` at index `wr_addr` on a clock edge only while reset is active. A write request while reset is inactive leaves the contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock; each rising edge advances the stream |
| rst_oe | input | 1 | Shared reset / output enable; polarity set by `RST_ACTIVE_HIGH` |
| standby | input | 1 | High puts the part in standby: counter frozen, output released |
| wr_en | input | 1 | Preload write strobe, honoured only during reset |
| wr_addr | input | $clog2(DEPTH) | Bit index for a preload write |
| wr_bit | input | 1 | Bit value for a preload write |
| data_bit | output | 1 | Registered serial data bit |
| data_oe | output | 1 | 1 when the data pin is driven, 0 for high impedance |

## Verification
The bench builds two instances of the block:
- The main instance uses `DEPTH`=16 with an active-low reset. With this depth, the terminal count, the saturation at the end of the stream, the constant-1 tail, and a mid-stream restart can all be reached within a few dozen clock edges.
- A second instance uses `DEPTH`=8 with an active-high reset, so the other polarity setting of the shared pin is exercised at its ports.

The main instance's contents are loaded twice with different patterns. This shows that each delivered bit comes from the written array and not from a fixed value.

// File: rtl/cfgrom_pkg.sv
// Shared definitions for the serial configuration memory.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package cfgrom_pkg;

    // Operating mode decoded from the control pins.
    typedef enum logic [1:0] {
        CR_HOLD = 2'd0,   // reset active: counter cleared, output released
        CR_RUN  = 2'd1,   // streaming: one bit per clock
        CR_PARK = 2'd2    // standby: everything frozen, output released
    } cr_mode_e;

endpackage

// File: rtl/cfgrom_ctrl.sv
// Control decode: turns the shared reset/output-enable pin and the standby
// pin into one operating mode. It also produces the output drive enable and
// the preload permission.
// Assumes: reset takes priority over standby; polarity is fixed at build.
module cfgrom_ctrl
    import cfgrom_pkg::*;
#(
    parameter bit RST_ACTIVE_HIGH = 1'b0
) (
    input  logic     rst_oe,
    input  logic     standby,
    output cr_mode_e mode,
    output logic     drive_en,
    output logic     load_ok
);

    logic rst_act;

    // Polarity variant of the shared pin, selected by parameter.
    generate
        if (RST_ACTIVE_HIGH) begin : g_pol_high
            assign rst_act = rst_oe;
        end else begin : g_pol_low
            assign rst_act = ~rst_oe;
        end
    endgenerate

    // Mode priority: reset over standby over run.
    always_comb begin
        if (rst_act) begin
            mode = CR_HOLD;
        end else if (standby) begin
            mode = CR_PARK;
        end else begin
            mode = CR_RUN;
        end
    end

    // The pin is driven only while streaming; preload is accepted only in reset.
    always_comb begin
        drive_en = (mode == CR_RUN);
        load_ok  = (mode == CR_HOLD);
    end

endmodule

// File: rtl/cfgrom_seq.sv
// Address sequencer: a saturating read pointer plus a flag. The flag marks
// that the bit at the terminal count has already been delivered.
// Assumes: DEPTH >= 2; mode comes from cfgrom_ctrl and is applied synchronously.
module cfgrom_seq
    import cfgrom_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  cr_mode_e      mode,
    output logic [AW-1:0] addr,
    output logic          past_end
);

    localparam logic [AW-1:0] TC = AW'(DEPTH - 1);

    // Pointer update: clear in reset, step while running, freeze at the end or in standby.
    always_ff @(posedge clk) begin
        case (mode)
            CR_HOLD: begin
                addr     <= '0;
                past_end <= 1'b0;
            end
            CR_RUN: begin
                if (!past_end) begin
                    if (addr == TC) begin
                        past_end <= 1'b1;
                    end else begin
                        addr <= addr + 1'b1;
                    end
                end
            end
            default: begin
                addr     <= addr;
                past_end <= past_end;
            end
        endcase
    end

endmodule

// File: rtl/cfgrom_store.sv
// Bit store: a DEPTH-bit array with a write port that only accepts writes when
// it is allowed, and a combinational read port.
// Assumes: out-of-range write indices are dropped.
module cfgrom_store #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_allow,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);

    logic [DEPTH-1:0] bits;

    // Preload write, gated by permission and range.
    always_ff @(posedge clk) begin
        if (wr_en && wr_allow && (int'(wr_addr) < DEPTH)) begin
            bits[wr_addr] <= wr_bit;
        end
    end

    // Read the bit under the pointer.
    always_comb begin
        rd_bit = bits[rd_addr];
    end

endmodule

// File: rtl/cfgrom_stream.sv
// Top level of the serial configuration memory. It joins the control decode,
// the address sequencer and the bit store, and holds the registered output bit.
// Assumes: cfg_clk is the only clock; rst_oe acts synchronously on the
// registers and combinationally on the output enable.
module cfgrom_stream
    import cfgrom_pkg::*;
#(
    parameter int DEPTH           = 2048,
    parameter bit RST_ACTIVE_HIGH = 1'b0,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          cfg_clk,
    input  logic          rst_oe,
    input  logic          standby,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    output logic          data_bit,
    output logic          data_oe
);

    cr_mode_e      mode;
    logic          drive_en;
    logic          load_ok;
    logic [AW-1:0] cur_addr;
    logic          past_end;
    logic          rd_bit;
    logic          data_q;

    cfgrom_ctrl #(
        .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
    ) u_ctrl (
        .rst_oe  (rst_oe),
        .standby (standby),
        .mode    (mode),
        .drive_en(drive_en),
        .load_ok (load_ok)
    );

    cfgrom_seq #(
        .DEPTH(DEPTH)
    ) u_seq (
        .clk     (cfg_clk),
        .mode    (mode),
        .addr    (cur_addr),
        .past_end(past_end)
    );

    cfgrom_store #(
        .DEPTH(DEPTH)
    ) u_store (
        .clk     (cfg_clk),
        .wr_allow(load_ok),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_bit  (wr_bit),
        .rd_addr (cur_addr),
        .rd_bit  (rd_bit)
    );

    // Output register: 1 in reset, next stored bit (or 1 past the end) when running.
    always_ff @(posedge cfg_clk) begin
        case (mode)
            CR_HOLD: data_q <= 1'b1;
            CR_RUN:  data_q <= past_end ? 1'b1 : rd_bit;
            default: data_q <= data_q;
        endcase
    end

    // Drive the output pins.
    always_comb begin
        data_bit = data_q;
        data_oe  = drive_en;
    end

endmodule

// File: rtl/cfgrom_stream_chk.sv
// Property checker for cfgrom_stream, attached by bind. It decodes the reset
// polarity on its own and watches the pins and the sequencer state.
// Assumes: checks start after the first edge seen with reset active.
module cfgrom_stream_chk #(
    parameter int DEPTH           = 2048,
    parameter bit RST_ACTIVE_HIGH = 1'b0,
    localparam int AW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_oe,
    input logic          standby,
    input logic          data_bit,
    input logic          data_oe,
    input logic [AW-1:0] addr,
    input logic          past_end
);

    localparam logic [AW-1:0] TC = AW'(DEPTH - 1);

    logic rst_act;
    logic primed = 1'b0;

    assign rst_act = RST_ACTIVE_HIGH ? rst_oe : ~rst_oe;

    // Arm the checks once a reset edge has been seen.
    always_ff @(posedge clk) begin
        if (rst_act) primed <= 1'b1;
    end

    a_r2_released_in_reset: assert property (@(posedge clk) disable iff (!primed)
        rst_act |-> !data_oe);

    a_r2_pointer_cleared: assert property (@(posedge clk) disable iff (!primed)
        rst_act |=> (addr == '0) && !past_end);

    a_r3_pointer_steps: assert property (@(posedge clk) disable iff (!primed)
        (!rst_act && !standby && !past_end && addr != TC) |=> addr == $past(addr) + 1'b1);

    a_r3_driven_when_running: assert property (@(posedge clk) disable iff (!primed)
        (!rst_act && !standby) |-> data_oe);

    a_r4_standby_frozen: assert property (@(posedge clk) disable iff (!primed)
        (!rst_act && standby) |=> $stable(addr) && $stable(data_bit) && $stable(past_end));

    a_r4_standby_released: assert property (@(posedge clk) disable iff (!primed)
        standby |-> !data_oe);

    a_r5_tail_is_one: assert property (@(posedge clk) disable iff (!primed)
        (!rst_act && !standby && past_end) |=> data_bit);

    a_r5_pointer_bounded: assert property (@(posedge clk) disable iff (!primed)
        addr <= TC);

endmodule

bind cfgrom_stream cfgrom_stream_chk #(
    .DEPTH          (DEPTH),
    .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
) u_chk (
    .clk     (cfg_clk),
    .rst_oe  (rst_oe),
    .standby (standby),
    .data_bit(data_bit),
    .data_oe (data_oe),
    .addr    (cur_addr),
    .past_end(past_end)
);

// File: tb/sim_cfgrom_stream.sv
// Scoreboard bench. The driver task applies one clock of stimulus and pushes
// the expected pins into a queue; the monitor pops and compares after each edge.
module sim_cfgrom_stream;

    localparam int D  = 16;
    localparam int AW = $clog2(D);

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic          rst_oe  = 1'b0;
    logic          standby = 1'b0;
    logic          wr_en   = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          wr_bit  = 1'b0;
    logic          dbit, doe;

    logic rst1 = 1'b1;
    logic d1, oe1;

    int checks = 0;
    int fails  = 0;

    cfgrom_stream #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b0)) u0 (
        .cfg_clk(clk), .rst_oe(rst_oe), .standby(standby),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit),
        .data_bit(dbit), .data_oe(doe)
    );

    cfgrom_stream #(.DEPTH(8), .RST_ACTIVE_HIGH(1'b1)) u1 (
        .cfg_clk(clk), .rst_oe(rst1), .standby(1'b0),
        .wr_en(1'b0), .wr_addr(3'd0), .wr_bit(1'b0),
        .data_bit(d1), .data_oe(oe1)
    );

    typedef struct {
        logic  oe;
        logic  d;
        string req;
    } exp_t;

    exp_t q[$];
    bit   img[D];
    int   ptr    = 0;
    logic last_d = 1'b1;

    // One clock: drive pins, then model the edge and queue the expectation.
    task automatic step(bit hold, bit stby, bit we, int wa, bit wb, string req);
        exp_t e;
        @(negedge clk);
        rst_oe  = hold ? 1'b0 : 1'b1;   // active-low build
        standby = stby;
        wr_en   = we;
        wr_addr = AW'(wa);
        wr_bit  = wb;
        @(posedge clk);
        if (hold) begin
            ptr = 0; last_d = 1'b1; e.oe = 1'b0; e.d = 1'b1;
            if (we) img[wa] = wb;
        end else if (stby) begin
            e.oe = 1'b0; e.d = last_d;
        end else begin
            e.d = (ptr < D) ? logic'(img[ptr]) : 1'b1;
            if (ptr < D) ptr++;
            last_d = e.d; e.oe = 1'b1;
        end
        e.req = req;
        q.push_back(e);
    endtask

    task automatic run(int n, string req);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 0, 1'b0, req);
    endtask

    task automatic load(int pat);
        for (int i = 0; i < D; i++) begin
            bit b = (pat == 0) ? bit'(((i >> 0) ^ (i >> 2)) & 1) : bit'((i * 7 + 3) % 5 < 2);
            step(1'b1, 1'b0, 1'b1, i, b, "R7");
        end
    endtask

    task automatic check_direct(logic act, logic expv, string req);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, expv);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    // Monitor: compare pins just after each edge against the queue.
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #1;
            while (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (doe !== e.oe || dbit !== e.d) begin
                    fails++;
                    $display("FAIL %s: got oe=%b d=%b expected oe=%b d=%b",
                             e.req, doe, dbit, e.oe, e.d);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        // R2: reset held, with standby both low and high.
        step(1'b1, 1'b0, 1'b0, 0, 1'b0, "R2");
        step(1'b1, 1'b1, 1'b0, 0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b0, 0, 1'b0, "R2");
        // R7: preload first pattern during reset.
        load(0);
        // R3: stream the first bits.
        run(5, "R3");
        // R7: write attempt while running must be ignored (bit 12 checked later).
        step(1'b0, 1'b0, 1'b1, 12, ~img[12], "R7");
        // R4: standby freezes, then resume.
        step(1'b0, 1'b1, 1'b0, 0, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b0, 0, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b0, 0, 1'b0, "R4");
        run(2, "R4");
        // Through the terminal count and past it (R5, R7 at bit 12).
        run(D - 8, "R7");
        run(4, "R5");
        step(1'b0, 1'b1, 1'b0, 0, 1'b0, "R5");
        run(2, "R5");
        // R6: restart mid-stream after reset.
        step(1'b1, 1'b0, 1'b0, 0, 1'b0, "R6");
        run(6, "R6");
        step(1'b1, 1'b0, 1'b0, 0, 1'b0, "R6");
        step(1'b1, 1'b0, 1'b0, 0, 1'b0, "R6");
        run(3, "R6");
        // Second pattern, full pass plus tail (R3, R5).
        step(1'b1, 1'b0, 1'b0, 0, 1'b0, "R2");
        load(1);
        run(D, "R3");
        run(3, "R5");
        // R1: active-high build and active-low build at the pin.
        @(negedge clk);
        rst1 = 1'b1;
        #1 check_direct(oe1, 1'b0, "R1");
        rst1 = 1'b0;
        #1 check_direct(oe1, 1'b1, "R1");
        rst_oe = 1'b0; standby = 1'b0;
        #1 check_direct(doe, 1'b0, "R1");
        rst_oe = 1'b1;
        #1 check_direct(doe, 1'b1, "R1");
        @(posedge clk);
        #2;
        report();
    end

endmodule